// File: doc/BRIEF.md
# Matched-Filter Neuron Discriminant Engine

This block scores how well the recent activity on a small group of electrodes matches one neuron's stored spike shape. On every sample strobe it takes the newest filtered value from each of its electrode slots, chosen from a wider input bus through a slot-to-source map, and writes it into a circular history. It then forms the dot product of that history with a matched-filter coefficient set and adds a per-neuron bias. The dot product uses a single multiplier, one product per clock. The scaled, rounded and clamped result comes out with a one-cycle valid pulse.

A host can rewrite coefficients, the bias and the map while sorting runs. Each write lands in a shadow copy. That copy is adopted as a whole at the next strobe, so no result mixes two configurations. A bank of these engines, one per neuron, feeds a later spike-decision stage.

Top module: `tmatch_disc`

## Requirements
- R1: After reset, `disc` is 0 and `disc_vld` is 0. All history entries, coefficients and the bias are zero, and slot e is mapped to source e.
- R2: For each strobe, the result is computed from acc = bias + sum over slots e and lags j of coef[e][j] * x_e(j). Here x_e(0) is the value captured at this strobe and x_e(j) the value captured j strobes earlier. Coefficient address = e*N_TAPS + j.
- R3: Each slot keeps its last N_TAPS captured values. Older values drop out, and history positions not yet written since reset count as zero.
- R4: At a strobe, slot e captures source map[e], which is bits [map[e]*TAP_W +: TAP_W] of `elec_bus`. The map entry for slot e is written with `cfg_sel`=2 and `cfg_addr`=e.
- R5: `disc_vld` is high for exactly one cycle, N_ELEC*N_TAPS+1 clock edges after the edge that samples `smp_stb`. The next strobe may not be sampled before that cycle.
- R6: The output is floor((acc + 2^(SHIFT-1)) / 2^SHIFT), which rounds half up. SHIFT defaults to 16.
- R7: Rounded values above 2^(OUT_W-1)-1 give 4095, and values below -2^(OUT_W-1) give -4096 (OUT_W=13).
- R8: Writes take effect only at the next strobe. `cfg_sel`=0 writes coefficients from the low COEF_W bits, and `cfg_sel`=1 writes the bias from all CFG_W bits, signed. Writes made while a result is being computed do not change that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | One-cycle sample strobe |
| elec_bus | input | N_SRC*TAP_W | Filtered samples of all candidate electrodes, signed |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Target: 0 coefficient, 1 bias, 2 map |
| cfg_addr | input | $clog2(N_ELEC*N_TAPS) | Coefficient index or slot number |
| cfg_data | input | CFG_W | Write data |
| disc | output | OUT_W | Signed discriminant |
| disc_vld | output | 1 | Result valid pulse |

## Verification
A wrong history pointer or a misrouted map entry corrupts the very next result. It also keeps skewing later results for up to N_TAPS strobes, as stale or misplaced samples slide through the lags. An impulse-free zero run, which must settle back to the bias alone, exposes any entry that fails to age out. A coefficient set adopted at the wrong moment shows up in the result of the strobe during which the write happened. A miscounted sequencer shows at the ports as a valid pulse off by a cycle, and every result is checked against the strobe-relative cycle number.

// File: rtl/tmatch_disc.sv
module tmatch_disc #(
  parameter int N_ELEC = 5,
  parameter int N_TAPS = 50,
  parameter int N_SRC  = 8,
  parameter int TAP_W  = 20,
  parameter int COEF_W = 14,
  parameter int OUT_W  = 13,
  parameter int CFG_W  = 24,
  parameter int SHIFT  = 16,
  localparam int TOT   = N_ELEC * N_TAPS,
  localparam int CA_W  = $clog2(TOT)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_stb,
  input  logic [N_SRC*TAP_W-1:0]   elec_bus,
  input  logic                     cfg_we,
  input  logic [1:0]               cfg_sel,
  input  logic [CA_W-1:0]          cfg_addr,
  input  logic [CFG_W-1:0]         cfg_data,
  output logic signed [OUT_W-1:0]  disc,
  output logic                     disc_vld
);
  localparam int PTR_W  = $clog2(N_TAPS);
  localparam int EW     = (N_ELEC > 1) ? $clog2(N_ELEC) : 1;
  localparam int SW     = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int PROD_W = TAP_W + COEF_W;
  localparam int ACC_W  = PROD_W + CA_W + 2;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (SHIFT - 1);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MINV = -ACC_W'(2 ** (OUT_W - 1));

  logic signed [TAP_W-1:0]  taps    [N_ELEC][N_TAPS];
  logic signed [COEF_W-1:0] coef_sh [TOT];
  logic signed [COEF_W-1:0] coef_act[TOT];
  logic signed [CFG_W-1:0]  bias_sh;
  logic [SW-1:0]            map_sh  [N_ELEC];

  logic [PTR_W-1:0] head, nxt, rd, j_cnt;
  logic [EW-1:0]    e_cnt;
  logic [CA_W-1:0]  k_cnt;
  logic             busy, last;
  logic signed [ACC_W-1:0]  acc, rnd, shf;
  logic signed [PROD_W-1:0] prod;

  assign nxt  = (head == PTR_W'(N_TAPS - 1)) ? '0 : head + 1'b1;
  assign rd   = (j_cnt <= head) ? head - j_cnt : head + PTR_W'(N_TAPS) - j_cnt;
  assign prod = taps[e_cnt][rd] * coef_act[k_cnt];
  assign rnd  = acc + HALF;
  assign shf  = rnd >>> SHIFT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < TOT; k++) coef_sh[k] <= '0;
      for (int e = 0; e < N_ELEC; e++) map_sh[e] <= SW'(e);
      bias_sh <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: if (cfg_addr < CA_W'(TOT)) coef_sh[cfg_addr] <= cfg_data[COEF_W-1:0];
        2'd1: bias_sh <= cfg_data;
        2'd2: if (cfg_addr < CA_W'(N_ELEC)) map_sh[cfg_addr[EW-1:0]] <= cfg_data[SW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < N_ELEC; e++)
        for (int j = 0; j < N_TAPS; j++) taps[e][j] <= '0;
      for (int k = 0; k < TOT; k++) coef_act[k] <= '0;
      head <= PTR_W'(N_TAPS - 1);
      acc <= '0; busy <= 1'b0; last <= 1'b0;
      j_cnt <= '0; e_cnt <= '0; k_cnt <= '0;
      disc <= '0; disc_vld <= 1'b0;
    end else begin
      disc_vld <= 1'b0;
      last <= 1'b0;
      if (smp_stb) begin
        head <= nxt;
        for (int e = 0; e < N_ELEC; e++)
          taps[e][nxt] <= elec_bus[map_sh[e]*TAP_W +: TAP_W];
        coef_act <= coef_sh;
        acc <= ACC_W'(bias_sh);
        busy <= 1'b1;
        j_cnt <= '0; e_cnt <= '0; k_cnt <= '0;
      end else if (busy) begin
        acc <= acc + ACC_W'(prod);
        k_cnt <= k_cnt + 1'b1;
        if (j_cnt == PTR_W'(N_TAPS - 1)) begin
          j_cnt <= '0;
          e_cnt <= e_cnt + 1'b1;
        end else begin
          j_cnt <= j_cnt + 1'b1;
        end
        if (k_cnt == CA_W'(TOT - 1)) begin
          busy <= 1'b0;
          last <= 1'b1;
        end
      end
      if (last) begin
        disc_vld <= 1'b1;
        disc <= (shf > MAXV) ? MAXV[OUT_W-1:0] :
                (shf < MINV) ? MINV[OUT_W-1:0] : shf[OUT_W-1:0];
      end
    end
  end

  p_vld_pulse_r5: assert property (@(posedge clk) disc_vld |=> !disc_vld);
  p_stb_starts_r5: assert property (@(posedge clk) disable iff (!rst_n) smp_stb |=> busy);
  p_no_early_stb_r5: assert property (@(posedge clk) disable iff (!rst_n) (busy || last) |-> !smp_stb);
  p_end_to_vld_r5: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |=> disc_vld);
  p_head_hold_r3: assert property (@(posedge clk) disable iff (!rst_n) !smp_stb |=> $stable(head));
  p_coef_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> ($stable(coef_act[0]) && $stable(coef_act[TOT-1])));
endmodule

// File: tb/sim_tmatch_disc.sv
module sim_tmatch_disc;
  localparam int NE = 5, NT = 50, NS = 8, TW = 20, TOT = NE * NT;
  logic clk = 0, rst_n = 0, smp_stb = 0, cfg_we = 0;
  logic [NS*TW-1:0] elec_bus = '0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_addr = '0;
  logic [23:0] cfg_data = '0;
  logic signed [12:0] disc;
  logic disc_vld;

  tmatch_disc u0 (.clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .elec_bus(elec_bus),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .disc(disc), .disc_vld(disc_vld));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  longint coef_m [TOT];
  longint bias_m = 0;
  int map_m [NE];
  longint hist [NE][NT];
  longint src_v [NS];
  longint q_val [$];
  int q_cyc [$];
  string q_tag [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input int sel, input int addr, input longint data);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_addr = 8'(addr); cfg_data = 24'(data);
    @(negedge clk);
    cfg_we = 0;
    if (sel == 0) coef_m[addr] = longint'($signed(14'(data)));
    else if (sel == 1) bias_m = longint'($signed(24'(data)));
    else map_m[addr] = int'(data) % NS;
  endtask

  task automatic strobe(input string tag, input int extra_cfg);
    longint a, r;
    @(negedge clk);
    for (int s = 0; s < NS; s++) elec_bus[s*TW +: TW] = TW'(src_v[s]);
    for (int e = 0; e < NE; e++) begin
      for (int j = NT - 1; j > 0; j--) hist[e][j] = hist[e][j-1];
      hist[e][0] = src_v[map_m[e]];
    end
    a = bias_m;
    for (int e = 0; e < NE; e++)
      for (int j = 0; j < NT; j++) a += coef_m[e*NT+j] * hist[e][j];
    r = (a + 32768) >>> 16;
    if (r > 4095) r = 4095;
    if (r < -4096) r = -4096;
    q_val.push_back(r); q_cyc.push_back(cyc + TOT + 2); q_tag.push_back(tag);
    smp_stb = 1;
    @(negedge clk);
    smp_stb = 0;
    if (extra_cfg != 0) begin
      cfg_wr(0, 0, 90); cfg_wr(0, 100, -77); cfg_wr(1, 0, -400000);
    end
    while (q_val.size() != 0) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && disc_vld) begin
      if (q_val.size() == 0) chk("R5 unexpected valid", 1, 0);
      else begin
        chk({q_tag[0], " value"}, disc, q_val[0]);
        chk("R5 valid cycle", cyc, q_cyc[0]);
        void'(q_val.pop_front()); void'(q_cyc.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  task automatic rand_src(input int lim);
    for (int s = 0; s < NS; s++) src_v[s] = longint'($urandom_range(2 * lim, 0)) - lim;
  endtask

  initial begin
    for (int k = 0; k < TOT; k++) coef_m[k] = 0;
    for (int e = 0; e < NE; e++) begin
      map_m[e] = e;
      for (int j = 0; j < NT; j++) hist[e][j] = 0;
    end
    for (int s = 0; s < NS; s++) src_v[s] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 disc reset", disc, 0);
    chk("R1 valid reset", disc_vld, 0);
    for (int s = 0; s < NS; s++) src_v[s] = 1000 * (s + 1);
    strobe("R1 zero coefficients", 0);
    for (int k = 0; k < TOT; k++) cfg_wr(0, k, ((k * 37) % 201) - 100);
    cfg_wr(1, 0, 123456);
    for (int i = 0; i < 6; i++) begin rand_src(2000); strobe("R2 random", 0); end
    for (int s = 0; s < NS; s++) src_v[s] = (s % 2 == 0) ? 1999 : -1999;
    strobe("R2 alternating", 0);
    for (int s = 0; s < NS; s++) src_v[s] = 0;
    for (int i = 0; i < NT + 1; i++) strobe("R3 history ageing", 0);
    cfg_wr(2, 0, 7); cfg_wr(2, 1, 0); cfg_wr(2, 2, 3); cfg_wr(2, 3, 3); cfg_wr(2, 4, 6);
    for (int i = 0; i < 3; i++) begin rand_src(2000); strobe("R4 remapped", 0); end
    rand_src(2000); strobe("R8 writes during compute", 1);
    rand_src(2000); strobe("R8 new set adopted", 0);
    for (int k = 0; k < TOT; k++) cfg_wr(0, k, 0);
    cfg_wr(1, 0, 32768); strobe("R6 half rounds up", 0);
    cfg_wr(1, 0, 32767); strobe("R6 below half", 0);
    cfg_wr(1, 0, -32768); strobe("R6 negative half", 0);
    cfg_wr(1, 0, -32769); strobe("R6 below negative half", 0);
    cfg_wr(1, 0, 98304); strobe("R6 one and a half", 0);
    cfg_wr(1, 0, 0);
    for (int e = 0; e < NE; e++) cfg_wr(0, e * NT, 8191);
    for (int s = 0; s < NS; s++) src_v[s] = 524287;
    strobe("R7 clamp high", 0);
    for (int s = 0; s < NS; s++) src_v[s] = -524288;
    strobe("R7 clamp low", 0);
    repeat (5) @(negedge clk);
    chk("R5 no stray results", q_val.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule